// File: doc/BRIEF.md
# Channel-Gain List Scan Sequencer

The block stores a short programmable list of channel and gain pairs and walks an analog-to-digital front end through it. Software fills the list by raising a load enable and writing pairs one after another. It then sets the index of the last entry to use and starts conversions. For every conversion the block issues a one-cycle convert strobe together with the channel and gain code of the selected entry. It then waits for the converter's done pulse before another conversion may begin.

Three operating styles are supported. In single-step mode each start request converts the next entry. In paced mode a start rearms the list at entry 0, and every later pacer tick converts one entry, looping for as long as the mode stays selected. In triggered-scan mode each start yields exactly one paced pass from entry 0 to the last entry and then stops. The present list index is always visible, so software can follow the scan.

Top module: `cgl_scan_seq`

## Requirements
- R1: The list holds 16 entries of a 4-bit channel and a 2-bit gain code. On every conversion, `chan_o` and `gain_o` carry the stored pair of the converted entry in the same cycle as `conv_o`, and they hold that pair until the next conversion.
- R2: While `load_en_i` is 1, each `wr_i` pulse stores the pair at the next location, beginning at entry 0 after `load_en_i` was 0. A `wr_i` pulse while `load_en_i` is 0 changes no entry.
- R3: After the entry at `final_addr_i` is converted, the present address returns to 0. Otherwise it advances by one.
- R4: With `mode_i` = 0 (single step), a start request seen while not busy produces `conv_o` in the next cycle for the entry at the present address, and the address advances.
- R5: With `mode_i` = 1 (paced), a start request while not busy sets the address to 0 and arms the scan. Each later `tick_i` seen while armed and not busy converts one entry, and the scan loops indefinitely.
- R6: With `mode_i` = 2 (triggered scan), a start arms one pass that converts entries 0 through `final_addr_i` on successive ticks. The scan then disarms, and further ticks convert nothing until the next start.
- R7: A tick that arrives in the same cycle as the start that arms a scan does not convert. The first conversion occurs on a later tick.
- R8: `addr_o` shows the present list address at all times. `busy_o` is 1 from a conversion strobe until the cycle after `done_i`.
- R9: A start request, or a tick that would convert in an armed mode, that arrives while busy pulses `trig_err_o` for one cycle. It is otherwise ignored: no conversion occurs and the address does not change.
- R10: `list_rst_i` sets the present address to 0 and rewinds the load position without altering stored entries. No conversion occurs in that cycle.
- R11: `ext_trig_i` acts as a start request only while `ext_trig_en_i` is 1. `sw_start_i` always acts as a start request.
- R12: With `mode_i` = 3, no conversion occurs, and start requests and ticks are ignored.
- R13: After reset, `conv_o`, `busy_o` and `trig_err_o` are 0, `addr_o` is 0, and all entries hold channel 0 and gain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 step, 1 paced loop, 2 triggered scan, 3 off |
| final_addr_i | input | 4 | Index of the last list entry used |
| load_en_i | input | 1 | Enables list writes; low rewinds the load position |
| wr_i | input | 1 | Write strobe for one list entry |
| wr_chan_i | input | 4 | Channel to store |
| wr_gain_i | input | 2 | Gain code to store |
| list_rst_i | input | 1 | Forces the present address to 0 |
| sw_start_i | input | 1 | Software start pulse |
| ext_trig_en_i | input | 1 | Lets the external trigger act as a start |
| ext_trig_i | input | 1 | External trigger pulse |
| tick_i | input | 1 | Pacer clock pulse |
| done_i | input | 1 | Converter finished the current conversion |
| conv_o | output | 1 | One-cycle convert strobe |
| chan_o | output | 4 | Channel of the latest conversion |
| gain_o | output | 2 | Gain code of the latest conversion |
| addr_o | output | 4 | Present list address |
| busy_o | output | 1 | Conversion in progress |
| trig_err_o | output | 1 | One-cycle pulse on a request made while busy |

## Verification
The assertions assume that the converter raises `done_i` only while the block reports busy, and one of them checks this assumption. The stimulus respects it by deriving `done_i` from the bench's own model of the busy state, with a random latency of one to three cycles after each strobe. All other inputs are random pulses, including starts and ticks that deliberately land while busy and in the same cycle as a start. Mode, last-entry index and load enable change occasionally. Directed sequences cover the wrap at a short final address, the disabled external trigger, list rewind, and one bounded triggered pass.

// File: rtl/cgl_pkg.sv
package cgl_pkg;
  localparam int unsigned DEF_DEPTH  = 16;
  localparam int unsigned DEF_CH_W   = 4;
  localparam int unsigned DEF_GAIN_W = 2;

  typedef enum logic [1:0] {
    MODE_STEP  = 2'b00,
    MODE_PACED = 2'b01,
    MODE_SCAN  = 2'b10,
    MODE_OFF   = 2'b11
  } scan_mode_e;
endpackage

// File: rtl/cgl_list_store.sv
module cgl_list_store #(
  parameter int unsigned DEPTH  = cgl_pkg::DEF_DEPTH,
  parameter int unsigned CH_W   = cgl_pkg::DEF_CH_W,
  parameter int unsigned GAIN_W = cgl_pkg::DEF_GAIN_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned EW    = CH_W + GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              wr_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [GAIN_W-1:0] wr_gain_i,
  input  logic              clr_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [CH_W-1:0]   rd_chan_o,
  output logic [GAIN_W-1:0] rd_gain_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DEPTH-1:0][EW-1:0] mem_q;
  logic [AW-1:0]            wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      wptr_q <= '0;
    end else if (!load_en_i || clr_i) begin
      wptr_q <= '0;
    end else if (wr_i) begin
      mem_q[wptr_q] <= {wr_chan_i, wr_gain_i};
      wptr_q        <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    end
  end

  assign {rd_chan_o, rd_gain_o} = mem_q[rd_addr_i];

  // R2
  hold_list_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> $stable(mem_q));

  // R2
  load_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> wptr_q == '0);

  // R10
  clr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> $stable(mem_q));
endmodule

// File: rtl/cgl_scan_ctrl.sv
module cgl_scan_ctrl
  import cgl_pkg::*;
#(
  parameter int unsigned DEPTH  = cgl_pkg::DEF_DEPTH,
  parameter int unsigned CH_W   = cgl_pkg::DEF_CH_W,
  parameter int unsigned GAIN_W = cgl_pkg::DEF_GAIN_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  scan_mode_e        mode_i,
  input  logic [AW-1:0]     final_addr_i,
  input  logic              start_ev_i,
  input  logic              tick_i,
  input  logic              done_i,
  input  logic              list_rst_i,
  input  logic [CH_W-1:0]   rd_chan_i,
  input  logic [GAIN_W-1:0] rd_gain_i,
  output logic [AW-1:0]     ptr_o,
  output logic              conv_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              busy_o,
  output logic              err_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]     ptr_q;
  logic              armed_q, busy_q, conv_q, err_q;
  logic [CH_W-1:0]   chan_q;
  logic [GAIN_W-1:0] gain_q;

  logic          at_final, paced_mode, do_tick;
  logic [AW-1:0] ptr_nxt;

  assign at_final   = (ptr_q == final_addr_i);
  assign ptr_nxt    = (at_final || ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign paced_mode = (mode_i == MODE_PACED) || (mode_i == MODE_SCAN);
  assign do_tick    = tick_i && armed_q && paced_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      conv_q  <= 1'b0;
      err_q   <= 1'b0;
      chan_q  <= '0;
      gain_q  <= '0;
    end else begin
      conv_q <= 1'b0;
      err_q  <= 1'b0;
      if (done_i) busy_q <= 1'b0;
      if (!paced_mode) armed_q <= 1'b0;
      if (list_rst_i) begin
        ptr_q <= '0;
      end else if (start_ev_i && mode_i != MODE_OFF) begin
        if (busy_q) begin
          err_q <= 1'b1;
        end else if (mode_i == MODE_STEP) begin
          conv_q <= 1'b1;
          busy_q <= 1'b1;
          chan_q <= rd_chan_i;
          gain_q <= rd_gain_i;
          ptr_q  <= ptr_nxt;
        end else begin
          // rearm only; first conversion waits for a later tick
          ptr_q   <= '0;
          armed_q <= 1'b1;
        end
      end else if (do_tick) begin
        if (busy_q) begin
          err_q <= 1'b1;
        end else begin
          conv_q <= 1'b1;
          busy_q <= 1'b1;
          chan_q <= rd_chan_i;
          gain_q <= rd_gain_i;
          ptr_q  <= ptr_nxt;
          if (mode_i == MODE_SCAN && at_final) armed_q <= 1'b0;
        end
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign conv_o = conv_q;
  assign chan_o = chan_q;
  assign gain_o = gain_q;
  assign busy_o = busy_q;
  assign err_o  = err_q;

  // R8
  done_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_q);

  // R9
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ev_i && busy_q && !list_rst_i && mode_i != MODE_OFF) |=> (err_q && !conv_q));

  // R3
  final_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_q && $past(ptr_q == final_addr_i)) |-> ptr_q == '0);

  // R6
  scan_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_q && $past(mode_i == MODE_SCAN && ptr_q == final_addr_i)) |-> !armed_q);

  // R7
  arm_no_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ev_i && !busy_q && !list_rst_i && paced_mode) |=> (!conv_q && ptr_q == '0));

  // R10
  list_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_rst_i |=> (ptr_q == '0 && !conv_q));

  // R12
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> !conv_q);
endmodule

// File: rtl/cgl_scan_seq.sv
module cgl_scan_seq
  import cgl_pkg::*;
#(
  parameter int unsigned DEPTH  = cgl_pkg::DEF_DEPTH,
  parameter int unsigned CH_W   = cgl_pkg::DEF_CH_W,
  parameter int unsigned GAIN_W = cgl_pkg::DEF_GAIN_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     final_addr_i,
  input  logic              load_en_i,
  input  logic              wr_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [GAIN_W-1:0] wr_gain_i,
  input  logic              list_rst_i,
  input  logic              sw_start_i,
  input  logic              ext_trig_en_i,
  input  logic              ext_trig_i,
  input  logic              tick_i,
  input  logic              done_i,
  output logic              conv_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [AW-1:0]     addr_o,
  output logic              busy_o,
  output logic              trig_err_o
);
  logic              start_ev;
  logic [AW-1:0]     ptr;
  logic [CH_W-1:0]   rd_chan;
  logic [GAIN_W-1:0] rd_gain;

  assign start_ev = sw_start_i || (ext_trig_en_i && ext_trig_i);

  cgl_list_store #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_en_i (load_en_i),
    .wr_i      (wr_i),
    .wr_chan_i (wr_chan_i),
    .wr_gain_i (wr_gain_i),
    .clr_i     (list_rst_i),
    .rd_addr_i (ptr),
    .rd_chan_o (rd_chan),
    .rd_gain_o (rd_gain)
  );

  cgl_scan_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (scan_mode_e'(mode_i)),
    .final_addr_i (final_addr_i),
    .start_ev_i   (start_ev),
    .tick_i       (tick_i),
    .done_i       (done_i),
    .list_rst_i   (list_rst_i),
    .rd_chan_i    (rd_chan),
    .rd_gain_i    (rd_gain),
    .ptr_o        (ptr),
    .conv_o       (conv_o),
    .chan_o       (chan_o),
    .gain_o       (gain_o),
    .busy_o       (busy_o),
    .err_o        (trig_err_o)
  );

  assign addr_o = ptr;
endmodule

// File: tb/cgl_scan_seq_tb.sv
module cgl_scan_seq_tb;
  localparam time CLK_P = 8ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd3;
  logic [3:0] final_addr_i = 4'd15;
  logic       load_en_i = 1'b0, wr_i = 1'b0;
  logic [3:0] wr_chan_i = '0;
  logic [1:0] wr_gain_i = '0;
  logic       list_rst_i = 1'b0, sw_start_i = 1'b0;
  logic       ext_trig_en_i = 1'b0, ext_trig_i = 1'b0;
  logic       tick_i = 1'b0, done_i = 1'b0;
  logic       conv_o, busy_o, trig_err_o;
  logic [3:0] chan_o, addr_o;
  logic [1:0] gain_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  logic [3:0] mc [16];
  logic [1:0] mg [16];
  logic [3:0] m_wptr = 0, m_ptr = 0;
  bit   m_armed = 0, m_busy = 0;
  bit   exp_conv = 0, exp_err = 0;
  logic [3:0] exp_chan = 0;
  logic [1:0] exp_gain = 0;
  int   dcnt = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  cgl_scan_seq u_dut (
    .clk_i, .rst_ni, .mode_i, .final_addr_i, .load_en_i, .wr_i, .wr_chan_i,
    .wr_gain_i, .list_rst_i, .sw_start_i, .ext_trig_en_i, .ext_trig_i,
    .tick_i, .done_i, .conv_o, .chan_o, .gain_o, .addr_o, .busy_o, .trig_err_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_conv();
    bit last;
    exp_conv = 1;
    exp_chan = mc[m_ptr];
    exp_gain = mg[m_ptr];
    last = (m_ptr == final_addr_i) || (m_ptr == 4'd15);
    m_ptr = last ? 4'd0 : m_ptr + 4'd1;
    m_busy = 1;
    dcnt = $urandom_range(0, 2);
    if (mode_i == 2'd2 && m_ptr == 4'd0) m_armed = 0;
  endtask

  task automatic step();
    bit b0, a0, sev;
    string tg;
    done_i = 1'b0;
    if (m_busy) begin
      if (dcnt == 0) done_i = 1'b1;
      else dcnt--;
    end
    @(posedge clk_i);
    exp_conv = 0; exp_err = 0;
    b0 = m_busy; a0 = m_armed;
    if (done_i) m_busy = 0;
    if (mode_i == 2'd0 || mode_i == 2'd3) m_armed = 0;
    sev = sw_start_i || (ext_trig_en_i && ext_trig_i);
    if (list_rst_i) m_ptr = 0;
    else if (sev && mode_i != 2'd3) begin
      if (b0) exp_err = 1;
      else if (mode_i == 2'd0) do_conv();
      else begin m_ptr = 0; m_armed = 1; end
    end else if (tick_i && a0 && (mode_i == 2'd1 || mode_i == 2'd2)) begin
      if (b0) exp_err = 1;
      else do_conv();
    end
    if (!load_en_i || list_rst_i) m_wptr = 0;
    else if (wr_i) begin
      mc[m_wptr] = wr_chan_i; mg[m_wptr] = wr_gain_i; m_wptr = m_wptr + 4'd1;
    end
    #1;
    case (mode_i)
      2'd0: tg = "R4";
      2'd1: tg = "R5";
      2'd2: tg = "R6";
      default: tg = "R12";
    endcase
    chk(conv_o == exp_conv, tg, "conv_o", conv_o, exp_conv);
    chk(addr_o == m_ptr, "R8", "addr_o", addr_o, m_ptr);
    chk(busy_o == m_busy, "R8", "busy_o", busy_o, m_busy);
    chk(trig_err_o == exp_err, "R9", "trig_err_o", trig_err_o, exp_err);
    if (exp_conv) begin
      chk(chan_o == exp_chan, "R1", "chan_o", chan_o, exp_chan);
      chk(gain_o == exp_gain, "R1", "gain_o", gain_o, exp_gain);
    end
  endtask

  task automatic drain();
    while (m_busy) step();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    int nconv;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin mc[i] = 0; mg[i] = 0; end
    #(CLK_P * 2 + 3ns);
    // R13 reset state
    chk(conv_o == 0, "R13", "conv_o", conv_o, 0);
    chk(busy_o == 0, "R13", "busy_o", busy_o, 0);
    chk(trig_err_o == 0, "R13", "trig_err_o", trig_err_o, 0);
    chk(addr_o == 0, "R13", "addr_o", addr_o, 0);
    rst_ni = 1'b1;
    #(CLK_P);

    // R2 load the list
    load_en_i = 1;
    for (int i = 0; i < 16; i++) begin
      wr_i = 1; wr_chan_i = 4'((i * 7) % 16); wr_gain_i = 2'(i % 4);
      step();
    end
    wr_i = 0; load_en_i = 0; step();
    wr_i = 1; wr_chan_i = 4'd15; wr_gain_i = 2'd3; step(); // ignored write
    wr_i = 0;

    // R2 / R4 step through full list
    mode_i = 2'd0; final_addr_i = 4'd15;
    for (int i = 0; i < 16; i++) begin
      sw_start_i = 1; step(); sw_start_i = 0;
      chk(conv_o == 1 && chan_o == 4'((i * 7) % 16) && gain_o == 2'(i % 4),
          "R2", "stored entry", chan_o, (i * 7) % 16);
      drain();
    end

    // R3 wrap at short final address
    final_addr_i = 4'd2;
    for (int i = 0; i < 4; i++) begin
      sw_start_i = 1; step(); sw_start_i = 0;
      chk(addr_o == 4'((i + 1) % 3), "R3", "addr after step", addr_o, (i + 1) % 3);
      drain();
    end

    // R11 disabled external trigger
    ext_trig_en_i = 0; ext_trig_i = 1; step(); ext_trig_i = 0;
    chk(conv_o == 0 && addr_o == 4'd1, "R11", "trigger ignored", conv_o, 0);
    ext_trig_en_i = 1; ext_trig_i = 1; step(); ext_trig_i = 0;
    chk(conv_o == 1, "R11", "trigger enabled", conv_o, 1);
    drain();

    // R10 list rewind keeps contents
    list_rst_i = 1; step(); list_rst_i = 0;
    chk(addr_o == 0, "R10", "addr after rewind", addr_o, 0);
    sw_start_i = 1; step(); sw_start_i = 0;
    chk(chan_o == 0 && gain_o == 0, "R10", "entry0 kept", chan_o, 0);
    drain();

    // R7 same-cycle tick does not convert
    mode_i = 2'd1; final_addr_i = 4'd3;
    sw_start_i = 1; tick_i = 1; step(); sw_start_i = 0;
    chk(conv_o == 0 && addr_o == 0, "R7", "no conv on arming tick", conv_o, 0);
    step();
    chk(conv_o == 1 && chan_o == 0, "R5", "first paced conv", conv_o, 1);
    for (int i = 0; i < 12; i++) step();
    tick_i = 0; drain();

    // R6 single pass in triggered scan
    mode_i = 2'd2; final_addr_i = 4'd1;
    sw_start_i = 1; step(); sw_start_i = 0; tick_i = 1;
    nconv = 0;
    for (int i = 0; i < 14; i++) begin step(); if (conv_o) nconv++; end
    tick_i = 0;
    chk(nconv == 2, "R6", "conversions in one pass", nconv, 2);
    drain();

    // random phase
    for (int n = 0; n < 5000; n++) begin
      sw_start_i    = ($urandom_range(0, 5) == 0);
      ext_trig_i    = ($urandom_range(0, 7) == 0);
      tick_i        = ($urandom_range(0, 2) == 0);
      list_rst_i    = ($urandom_range(0, 59) == 0);
      wr_i          = ($urandom_range(0, 3) == 0);
      wr_chan_i     = 4'($urandom);
      wr_gain_i     = 2'($urandom);
      if ($urandom_range(0, 39) == 0) load_en_i = ~load_en_i;
      if ($urandom_range(0, 29) == 0) ext_trig_en_i = ~ext_trig_en_i;
      if ($urandom_range(0, 149) == 0) mode_i = 2'($urandom);
      if ($urandom_range(0, 79) == 0) final_addr_i = 4'($urandom);
      step();
    end
    sw_start_i = 0; ext_trig_i = 0; tick_i = 0; list_rst_i = 0; wr_i = 0;
    drain();
    finish_run();
  end
endmodule